// File: doc/BRIEF.md
# I2C Auto-Mode Master Sequencer

This block is an I2C bus master that carries out a complete read or write from a single command word. Software writes the target address and a command holding the byte count, the direction and whether to finish with STOP, and sets the run bit. The engine then issues START, sends the address byte, and moves the requested number of bytes. Bytes to send come from a transmit FIFO and received bytes go to a receive FIFO. The engine ends with STOP, or it keeps the bus so that the next command opens with a repeated START. Nothing is needed from software between bytes.

The engine does not generate SCL/SDA waveforms itself. It asks a separate timing generator for one bus operation at a time (START, write one bit, read one bit, STOP). It holds the request until the generator returns a one-cycle done strobe, together with the sampled bit and an arbitration-lost flag. When a transaction ends, exactly one sticky result bit is set: success, lost arbitration, data NACK, missing device, or stall timeout. A completion interrupt is also raised and stays up until software writes 1 to its bit. Addresses are sent in 7-bit form, taken from the low seven bits of the 10-bit target field.

Top module: `i2c_auto_master`

## Requirements
- R1: When `cmd_wr` is high, the engine is idle and `cmd_word` has bit 31 (run) set and a nonzero count in bits [15:0], the engine starts. It requests START, then sends the byte {`addr_word[16:10]`, `cmd_word[16]`} MSB first (bit 16 = 1 means read). Bus operations are coded on `bit_op` as 0 START, 1 write bit, 2 read bit, 3 STOP. Each request holds steady until `bit_done`. Busy is `trans_stat[17]`.
- R2: A write sends the count of bytes from the TX FIFO in push order, MSB first, and reads an ACK bit after each. If every byte is ACKed, it reports success in `trans_stat[0]`. STOP is issued when `cmd_word[17]` was set.
- R3: A read fills the RX FIFO with the count of bytes. The master drives ACK (0) after every byte except the last, which gets NACK (1).
- R4: When `cmd_word[17]` is clear, no STOP is issued, busy drops after the last byte, and the next command's START is a repeated START on a held bus.
- R5: A NACK to the address byte sets `trans_stat[3]` (no device) and issues STOP. The TX FIFO is not touched.
- R6: A NACK to a written data byte sets `trans_stat[2]` and issues STOP. No further data byte is sent.
- R7: If `bit_arb_lost` comes with `bit_done`, `trans_stat[1]` is set and the engine goes idle without a STOP.
- R8: While a write has bytes left and the TX FIFO is empty, no bus operation is requested (SCL stays held). The transfer resumes when a byte is pushed.
- R9: If that stall, or a read stall on a full RX FIFO, lasts `TMO_CYC` cycles, `trans_stat[4]` is set and STOP is issued.
- R10: At the end of every transaction `int_stat[9]` and `irq` rise. Writing with `int_clr_data[9]`=1 clears them, and a write with bit 9 clear has no effect. The result bits stay set until the next accepted command, and at most one of bits [4:0] is ever set.
- R11: A command with a count of zero is ignored. No START is issued, the engine does not go busy and no interrupt is raised.
- R12: Busy stays high for as long as STOP is requested. It drops in the cycle after STOP's `bit_done`.
- R13: While `ctl_word[31]` is high the engine is idle, both FIFOs are empty, no bus operation is requested and busy is clear.
- R14: `fifo_stat` reports RX empty at bit 24, RX full at 23, RX level at [22:16], TX empty at 8, TX full at 7 and TX level at [6:0]. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_word | input | 32 | Control; bit 31 holds the engine in soft reset |
| addr_word | input | 32 | Target address field in [19:10] |
| cmd_word | input | 32 | Count [15:0], read 16, stop 17, run 31 |
| cmd_wr | input | 1 | Command write strobe |
| tx_wdata | input | 8 | Byte to queue for sending |
| tx_push | input | 1 | Push into TX FIFO |
| rx_pop | input | 1 | Pop from RX FIFO |
| rx_rdata | output | 8 | Head of RX FIFO |
| fifo_stat | output | 32 | FIFO flags and levels |
| trans_stat | output | 32 | Result bits [4:0], busy at 17 |
| int_clr_wr | input | 1 | Interrupt status write strobe |
| int_clr_data | input | 32 | Write-1-to-clear data; bit 9 is completion |
| int_stat | output | 32 | Interrupt status; bit 9 is completion |
| irq | output | 1 | Completion interrupt |
| bit_req | output | 1 | Bus operation requested |
| bit_op | output | 2 | Operation code |
| bit_txd | output | 1 | Bit to drive for a write-bit operation |
| bit_done | input | 1 | Operation finished (one cycle) |
| bit_rxd | input | 1 | Bit sampled by a read-bit operation |
| bit_arb_lost | input | 1 | Arbitration was lost during the operation |

## Verification
A wrong state in the sequencer shows up as a wrong bus operation at `bit_op` within one generator round-trip. Examples are a missing or extra STOP, a shifted byte, or a master ACK on the final read byte. Errors in the byte counter or the result code show up when `irq` rises: the delivered byte count or the set status bit differs from what the bench expects for that transaction. Stall and timeout faults are caught by watching `bit_req` stay low through the stall window, and by the exact moment the timeout status appears.

// File: rtl/i2c_auto_master.sv
module i2c_auto_master #(
  parameter int DEPTH   = 8,
  parameter int LEN_W   = 16,
  parameter int TMO_CYC = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ctl_word,
  input  logic [31:0] addr_word,
  input  logic [31:0] cmd_word,
  input  logic        cmd_wr,
  input  logic [7:0]  tx_wdata,
  input  logic        tx_push,
  input  logic        rx_pop,
  output logic [7:0]  rx_rdata,
  output logic [31:0] fifo_stat,
  output logic [31:0] trans_stat,
  input  logic        int_clr_wr,
  input  logic [31:0] int_clr_data,
  output logic [31:0] int_stat,
  output logic        irq,
  output logic        bit_req,
  output logic [1:0]  bit_op,
  output logic        bit_txd,
  input  logic        bit_done,
  input  logic        bit_rxd,
  input  logic        bit_arb_lost
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam int TW = $clog2(TMO_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_AACK, S_WLOAD, S_WBIT, S_WACK,
    S_RWAIT, S_RBIT, S_RACK, S_STOP
  } st_t;

  st_t              st;
  logic [7:0]       shreg;
  logic [2:0]       bcnt;
  logic [LEN_W-1:0] remain;
  logic             is_rd, do_stop;
  logic [4:0]       err, res;
  logic [TW-1:0]    tmo;
  logic             int_fin;

  logic srst;
  assign srst = ctl_word[31];

  logic [7:0]    txm [DEPTH];
  logic [7:0]    rxm [DEPTH];
  logic [AW-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic tx_full, tx_empty, rx_full, rx_empty;
  assign tx_full  = tx_cnt == CW'(DEPTH);
  assign tx_empty = tx_cnt == '0;
  assign rx_full  = rx_cnt == CW'(DEPTH);
  assign rx_empty = rx_cnt == '0;

  logic tx_do_push, tx_do_pop, rx_do_push, rx_do_pop;
  assign tx_do_push = tx_push && !tx_full && !srst;
  assign tx_do_pop  = (st == S_WLOAD) && !tx_empty && !srst;
  assign rx_do_push = (st == S_RACK) && bit_done && !bit_arb_lost && !srst;
  assign rx_do_pop  = rx_pop && !rx_empty && !srst;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (tx_do_push) txm[tx_wp] <= tx_wdata;
    if (rx_do_push) rxm[rx_wp] <= shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
    end else if (srst) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_do_push) tx_wp <= nxt(tx_wp);
      if (tx_do_pop)  tx_rp <= nxt(tx_rp);
      if (rx_do_push) rx_wp <= nxt(rx_wp);
      if (rx_do_pop)  rx_rp <= nxt(rx_rp);
      tx_cnt <= tx_cnt + CW'(tx_do_push) - CW'(tx_do_pop);
      rx_cnt <= rx_cnt + CW'(rx_do_push) - CW'(rx_do_pop);
    end
  end

  assign rx_rdata = rxm[rx_rp];

  logic busy, last, accept;
  assign busy   = st != S_IDLE;
  assign last   = remain == LEN_W'(1);
  assign accept = cmd_wr && cmd_word[31] && (cmd_word[LEN_W-1:0] != '0) && !busy;

  always_comb begin
    bit_req = 1'b1;
    bit_op  = 2'd1;
    case (st)
      S_START:                bit_op = 2'd0;
      S_ADDR, S_WBIT, S_RACK: bit_op = 2'd1;
      S_AACK, S_WACK, S_RBIT: bit_op = 2'd2;
      S_STOP:                 bit_op = 2'd3;
      default:                bit_req = 1'b0;
    endcase
  end
  assign bit_txd = (st == S_RACK) ? last : shreg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; shreg <= '0; bcnt <= '0; remain <= '0;
      is_rd <= 1'b0; do_stop <= 1'b0; err <= '0; res <= '0; tmo <= '0;
      int_fin <= 1'b0;
    end else if (srst) begin
      st <= S_IDLE; shreg <= '0; bcnt <= '0; remain <= '0;
      is_rd <= 1'b0; do_stop <= 1'b0; err <= '0; res <= '0; tmo <= '0;
      int_fin <= 1'b0;
    end else begin
      if (int_clr_wr && int_clr_data[9]) int_fin <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          st      <= S_START;
          remain  <= cmd_word[LEN_W-1:0];
          is_rd   <= cmd_word[16];
          do_stop <= cmd_word[17];
          shreg   <= {addr_word[16:10], cmd_word[16]};
          err     <= '0;
          res     <= '0;
          tmo     <= '0;
        end
        S_WLOAD, S_RWAIT: begin
          if ((st == S_WLOAD) ? !tx_empty : !rx_full) begin
            if (st == S_WLOAD) shreg <= txm[tx_rp];
            bcnt <= '0;
            tmo  <= '0;
            st   <= (st == S_WLOAD) ? S_WBIT : S_RBIT;
          end else if (tmo == TW'(TMO_CYC - 1)) begin
            err <= 5'b10000;
            st  <= S_STOP;
          end else begin
            tmo <= tmo + TW'(1);
          end
        end
        default: if (bit_done) begin
          if (bit_arb_lost && st != S_STOP) begin
            res <= 5'b00010; int_fin <= 1'b1; st <= S_IDLE;
          end else begin
            case (st)
              S_START: begin bcnt <= '0; st <= S_ADDR; end
              S_ADDR, S_WBIT: begin
                shreg <= {shreg[6:0], 1'b0};
                bcnt  <= bcnt + 3'd1;
                if (bcnt == 3'd7) st <= (st == S_ADDR) ? S_AACK : S_WACK;
              end
              S_AACK: begin
                if (bit_rxd) begin err <= 5'b01000; st <= S_STOP; end
                else st <= is_rd ? S_RWAIT : S_WLOAD;
              end
              S_RBIT: begin
                shreg <= {shreg[6:0], bit_rxd};
                bcnt  <= bcnt + 3'd1;
                if (bcnt == 3'd7) st <= S_RACK;
              end
              S_WACK, S_RACK: begin
                remain <= remain - LEN_W'(1);
                if (st == S_WACK && bit_rxd) begin
                  err <= 5'b00100; st <= S_STOP;
                end else if (!last) begin
                  st <= (st == S_WACK) ? S_WLOAD : S_RWAIT;
                end else if (do_stop) begin
                  st <= S_STOP;
                end else begin
                  res <= 5'b00001; int_fin <= 1'b1; st <= S_IDLE;
                end
              end
              S_STOP: begin
                res <= (err == '0) ? 5'b00001 : err;
                int_fin <= 1'b1;
                st <= S_IDLE;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign fifo_stat  = {7'b0, rx_empty, rx_full, 7'(rx_cnt), 7'b0, tx_empty, tx_full, 7'(tx_cnt)};
  assign trans_stat = {14'b0, busy, 12'b0, res};
  assign int_stat   = {22'b0, int_fin, 9'b0};
  assign irq        = int_fin;

  logic unused_bits;
  assign unused_bits = &{1'b0, ctl_word[30:0], addr_word[31:17], addr_word[9:0],
                         cmd_word[30:18], cmd_word[15:LEN_W], int_clr_data[31:10],
                         int_clr_data[8:0]};
endmodule

// File: rtl/i2c_auto_master_chk.sv
module i2c_auto_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctl_word,
  input logic [31:0] cmd_word,
  input logic        cmd_wr,
  input logic [31:0] fifo_stat,
  input logic [31:0] trans_stat,
  input logic        irq,
  input logic        bit_req,
  input logic [1:0]  bit_op,
  input logic        bit_txd,
  input logic        bit_done
);
  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n || ctl_word[31])
    (bit_req && !bit_done) |=> (bit_req && $stable(bit_op) && $stable(bit_txd)));

  a_r12_busy_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && bit_op == 2'd3) |-> trans_stat[17]);

  a_r10_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trans_stat[4:0]));

  a_r10_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n || ctl_word[31])
    $rose(irq) |-> $fell(trans_stat[17]));

  a_r11_zero_len: assert property (@(posedge clk) disable iff (!rst_n || ctl_word[31])
    (cmd_wr && cmd_word[31] && cmd_word[15:0] == 16'd0 && !trans_stat[17]) |=> !trans_stat[17]);

  a_r13_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_word[31] |=> (!bit_req && !trans_stat[17] && fifo_stat[24] && fifo_stat[8]));

  a_r14_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_stat[24] && fifo_stat[23]) && !(fifo_stat[8] && fifo_stat[7]));
endmodule

bind i2c_auto_master i2c_auto_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .cmd_word(cmd_word), .cmd_wr(cmd_wr),
  .fifo_stat(fifo_stat), .trans_stat(trans_stat), .irq(irq), .bit_req(bit_req),
  .bit_op(bit_op), .bit_txd(bit_txd), .bit_done(bit_done)
);

// File: tb/i2c_auto_master_bench.sv
`timescale 1ns/1ps
module i2c_auto_master_bench;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [31:0] ctl_word = 0, addr_word = 0, cmd_word = 0, int_clr_data = 0;
  logic cmd_wr = 0, tx_push = 0, rx_pop = 0, int_clr_wr = 0;
  logic [7:0] tx_wdata = 0, rx_rdata;
  logic [31:0] fifo_stat, trans_stat, int_stat;
  logic irq, bit_req, bit_txd;
  logic [1:0] bit_op;
  logic bit_done = 0, bit_rxd = 1, bit_arb_lost = 0;

  i2c_auto_master #(.DEPTH(8), .LEN_W(16), .TMO_CYC(200)) u_i2c_auto_master (.*);

  int nvec = 0, nerr = 0;
  bit stall_win = 0, ended = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // slave / timing generator model
  logic [6:0] dev = 7'h2A;
  int nack_at = -1, arb_at = -1, rd_idx = 0;
  logic [7:0] rd_base = 8'hA0;
  int s_phase = 0, s_bits = 0, s_abits = 0, s_wcnt = 0;
  logic [7:0] s_sh = 0;
  logic s_rd = 0;
  int ev_q[$];
  logic [7:0] wr_q[$];
  logic [7:0] addr_q[$];
  logic mack_q[$];

  task automatic slave_event(input int op, input logic txd, output logic rxd, output logic arb);
    logic [7:0] rb;
    rxd = 1; arb = 0;
    case (op)
      0: begin
        ev_q.push_back(s_phase != 0 ? 2 : 1);
        s_phase = 1; s_bits = 0; s_abits = 0; s_wcnt = 0;
      end
      1: if (s_phase == 2 && s_rd && s_bits == 8) begin
           mack_q.push_back(txd); s_bits = 0;
         end else begin
           if (s_phase == 1 && s_abits == arb_at) begin arb = 1; s_phase = 0; end
           if (s_phase == 1) s_abits++;
           s_sh = {s_sh[6:0], txd}; s_bits++;
         end
      2: if (s_bits == 8) begin
           if (s_phase == 1) begin
             addr_q.push_back(s_sh); s_rd = s_sh[0];
             rxd = (s_sh[7:1] == dev) ? 1'b0 : 1'b1;
             s_phase = rxd ? 3 : 2;
           end else begin
             wr_q.push_back(s_sh);
             rxd = (s_wcnt == nack_at);
             s_wcnt++;
           end
           s_bits = 0;
         end else begin
           rb = rd_base + 8'(rd_idx);
           rxd = rb[7 - s_bits]; s_bits++;
           if (s_bits == 8) rd_idx++;
         end
      default: begin ev_q.push_back(3); s_phase = 0; end
    endcase
  endtask

  initial begin
    int op; logic txd, rx, ab;
    forever begin
      @(negedge clk);
      bit_done = 0; bit_arb_lost = 0;
      if (bit_req) begin
        op = int'(bit_op); txd = bit_txd;
        repeat (2) @(negedge clk);
        if (bit_req) begin
          slave_event(op, txd, rx, ab);
          bit_rxd = rx; bit_arb_lost = ab; bit_done = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && bit_req && bit_op == 2'd3) chk("R12 busy during STOP", {31'b0, trans_stat[17]}, 1);
    if (stall_win) chk("R8 no request while TX empty", {31'b0, bit_req}, 0);
  end

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic push(input logic [7:0] b);
    @(negedge clk); tx_wdata = b; tx_push = 1;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic run_cmd(input int len, input logic rd, input logic stp);
    @(negedge clk);
    cmd_word = {1'b1, 13'b0, stp, rd, 16'(len)}; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic wait_irq(input string rq);
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    if (!irq) chk(rq, 0, 1);
  endtask

  task automatic clr_irq(input logic b9);
    @(negedge clk); int_clr_data = {22'b0, b9, 9'b0}; int_clr_wr = 1;
    @(negedge clk); int_clr_wr = 0;
  endtask

  task automatic pop_chk(input string rq, input logic [7:0] exp);
    @(negedge clk); chk(rq, {24'b0, rx_rdata}, {24'b0, exp}); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  initial begin
    int ev0;
    addr_word = {12'b0, 3'b0, dev, 10'b0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R14 reset fifo_stat", fifo_stat, 32'h0100_0100);
    chk("R10 reset trans_stat", trans_stat, 0);
    chk("R10 reset irq", {31'b0, irq}, 0);

    // R1/R2 write of 3 bytes with STOP
    push(8'h5C); push(8'h81); push(8'h3E);
    chk("R14 tx level 3", {23'b0, fifo_stat[8:0]}, 32'h3);
    run_cmd(3, 0, 1);
    @(negedge clk);
    chk("R1 busy after run", {31'b0, trans_stat[17]}, 1);
    wait_irq("R2 write completes");
    chk("R1 address byte", {24'b0, addr_q[0]}, {24'b0, dev, 1'b0});
    chk("R2 byte count", wr_q.size(), 3);
    chk("R2 byte0", {24'b0, wr_q[0]}, 32'h5C);
    chk("R2 byte2", {24'b0, wr_q[2]}, 32'h3E);
    chk("R2 success", trans_stat, 32'h0000_0001);
    chk("R2 START then STOP", {ev_q[0], ev_q[ev_q.size()-1]}, {32'd1, 32'd3});
    chk("R14 tx empty after", fifo_stat[8:0], 9'h100);

    // R10 interrupt clear semantics
    chk("R10 int bit9", int_stat, 32'h200);
    clr_irq(0);
    chk("R10 write without bit9 ignored", {31'b0, irq}, 1);
    clr_irq(1);
    chk("R10 cleared by writing 1", {31'b0, irq}, 0);
    chk("R10 result sticky", trans_stat[4:0], 5'b00001);

    // R3 read of 4 bytes
    rd_idx = 0; mack_q.delete(); addr_q.delete();
    run_cmd(4, 1, 1);
    wait_irq("R3 read completes");
    chk("R3 address byte read", {24'b0, addr_q[0]}, {24'b0, dev, 1'b1});
    chk("R14 rx level 4", {16'b0, fifo_stat[31:16]}, 32'h0004);
    chk("R3 master ack bits", {mack_q[0], mack_q[1], mack_q[2], mack_q[3]}, 4'b0001);
    for (int i = 0; i < 4; i++) pop_chk("R3 read data", 8'hA0 + 8'(i));
    chk("R14 rx empty", {7'b0, fifo_stat[24:16]}, 32'h100);
    clr_irq(1);

    // R4 write without STOP then read with repeated START
    ev_q.delete(); wr_q.delete();
    push(8'h11);
    run_cmd(1, 0, 0);
    wait_irq("R4 held write completes");
    @(negedge clk);
    chk("R4 busy cleared without STOP", {31'b0, trans_stat[17]}, 0);
    chk("R4 no STOP issued", ev_q.size(), 1);
    clr_irq(1);
    rd_idx = 0;
    run_cmd(2, 1, 1);
    wait_irq("R4 read completes");
    chk("R4 repeated START", ev_q[1], 2);
    pop_chk("R4 data0", 8'hA0); pop_chk("R4 data1", 8'hA1);
    clr_irq(1);

    // R8 stall on empty TX FIFO
    wr_q.delete();
    push(8'h77);
    run_cmd(2, 0, 1);
    while (wr_q.size() < 1) @(negedge clk);
    repeat (4) @(negedge clk);
    stall_win = 1;
    repeat (50) @(negedge clk);
    stall_win = 0;
    chk("R8 still busy while stalled", {31'b0, trans_stat[17]}, 1);
    push(8'h78);
    wait_irq("R8 resumes");
    chk("R8 second byte sent", {24'b0, wr_q[1]}, 32'h78);
    chk("R8 success", trans_stat[4:0], 5'b00001);
    clr_irq(1);

    // R9 timeout
    wr_q.delete(); ev_q.delete();
    push(8'h42);
    run_cmd(2, 0, 1);
    wait_irq("R9 timeout completes");
    chk("R9 timeout code", trans_stat[4:0], 5'b10000);
    chk("R9 STOP after timeout", ev_q[ev_q.size()-1], 3);
    chk("R9 one byte sent", wr_q.size(), 1);
    clr_irq(1);

    // R11 zero length ignored
    ev0 = ev_q.size();
    run_cmd(0, 0, 1);
    repeat (20) @(negedge clk);
    chk("R11 not busy", {31'b0, trans_stat[17]}, 0);
    chk("R11 no START", ev_q.size(), ev0);
    chk("R11 no irq", {31'b0, irq}, 0);

    // R6 data NACK
    wr_q.delete(); ev_q.delete(); nack_at = 1;
    push(8'hD1); push(8'hD2); push(8'hD3);
    run_cmd(3, 0, 1);
    wait_irq("R6 nack completes");
    chk("R6 no-ack code", trans_stat[4:0], 5'b00100);
    chk("R6 bytes sent", wr_q.size(), 2);
    chk("R6 STOP issued", ev_q[ev_q.size()-1], 3);
    chk("R6 byte left in TX", {25'b0, fifo_stat[6:0]}, 1);
    nack_at = -1;
    clr_irq(1);

    // R5 no device
    ev_q.delete(); dev = 7'h33;
    run_cmd(1, 0, 1);
    wait_irq("R5 nodev completes");
    chk("R5 no-device code", trans_stat[4:0], 5'b01000);
    chk("R5 STOP issued", ev_q[ev_q.size()-1], 3);
    chk("R5 TX untouched", {25'b0, fifo_stat[6:0]}, 1);
    dev = 7'h2A;
    clr_irq(1);

    // R13 soft reset mid-command
    run_cmd(3, 0, 1);
    @(negedge clk); ctl_word = 32'h8000_0000;
    @(negedge clk);
    chk("R13 idle in soft reset", {31'b0, trans_stat[17]}, 0);
    chk("R13 no request", {31'b0, bit_req}, 0);
    chk("R13 fifos empty", fifo_stat, 32'h0100_0100);
    @(negedge clk); ctl_word = 0;
    s_phase = 0;
    repeat (5) @(negedge clk);

    // R7 arbitration lost
    ev_q.delete(); arb_at = 3;
    run_cmd(1, 1, 1);
    wait_irq("R7 arb completes");
    @(negedge clk);
    chk("R7 abort code", trans_stat, 32'h0000_0002);
    chk("R7 no STOP", ev_q.size(), 1);
    arb_at = -1;
    clr_irq(1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule